// File: doc/BRIEF.md
# Block Address Translation Array

This block resolves the final physical address of a memory access. A small set of block translation entries is searched at the same time as the page translation path that sits next to it. Each entry maps one naturally aligned region of the effective space to a physical region. The region can be anywhere from 128 KB to 256 MB, and its size is selected by a per-entry length mask.

When an entry matches, its physical block number replaces the upper address bits, and any page result offered in the same cycle is dropped without notice. When no entry matches, the page result is used. When translation is switched off, the effective address is passed through unchanged.

The result is registered, so it appears one cycle after the request. The entries are loaded through a simple write port.

Top module: `bat_xlate`

## Requirements
- R1: After reset all entries are invalid and `pa`, `pa_valid`, `miss` and `bat_hit` are 0.
- R2: With `xlate_en` low, one cycle later `pa` equals the effective address, `pa_valid`=1, and `miss`=0 and `bat_hit`=0, whatever the entries or the page inputs hold.
- R3: An entry matches when it is valid and `ea[31:17]` equals its effective block index in every bit. The one exception is bits `ea[27:17]` whose length-mask bit is 1 (mask bit k covers `ea[17+k]`). Bits `ea[31:28]` are always compared.
- R4: On a match, `pa[31:17]` takes the entry's physical block number, except for the masked bits, which are copied from `ea`. `pa[16:0]` always equals `ea[16:0]`.
- R5: On a match with `xlate_en` high, `bat_hit`=1 and `pa_valid`=1, and `pg_pa` is ignored even when `pg_valid`=1.
- R6: With `xlate_en` high, no match and `pg_valid`=1, one cycle later `pa`=`pg_pa`, `pa_valid`=1, and `bat_hit`=0 and `miss`=0.
- R7: With `xlate_en` high, no match and `pg_valid`=0, one cycle later `pa_valid`=0, `miss`=1 and `pa`=0.
- R8: When several entries match, the lowest-numbered one supplies the address.
- R9: When `bat_we` is high, entry `bat_idx` is loaded at the clock edge with `bat_wvalid`, `bat_wepn`, `bat_wppn` and `bat_wmask`. A lookup in the same cycle still sees the old contents. Length masks must be contiguous ones starting from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ea | input | 32 | Effective address |
| xlate_en | input | 1 | Translation enable (0 = real mode) |
| pg_valid | input | 1 | Page translation result valid |
| pg_pa | input | 32 | Page translation physical address |
| bat_we | input | 1 | Entry write strobe |
| bat_idx | input | 2 | Entry number to write |
| bat_wvalid | input | 1 | Valid bit to write |
| bat_wepn | input | 15 | Effective block index to write |
| bat_wppn | input | 15 | Physical block number to write |
| bat_wmask | input | 11 | Length mask to write |
| pa | output | 32 | Physical address (registered) |
| pa_valid | output | 1 | Physical address valid |
| miss | output | 1 | Neither block nor page translation resolved the access |
| bat_hit | output | 1 | Address came from a block entry |

## Verification
An entry write and a lookup can fall in the same cycle. The bench provokes this by loading entry 0 while it presents an address that the new contents would match, with a valid page result alongside. The correct outcome is the page address with `bat_hit` low, and only the following lookup should hit. A second collision happens inside the lookup itself: a block hit and a valid page result arrive together. The bench checks that the block address wins and that `pg_pa` leaves no trace in `pa`.

// File: rtl/bat_xlate.sv
module bat_xlate #(
  parameter int AW   = 32,
  parameter int OFFW = 17,
  parameter int NENT = 4,
  parameter int MW   = 11,
  localparam int BW  = AW - OFFW,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ea,
  input  logic          xlate_en,
  input  logic          pg_valid,
  input  logic [AW-1:0] pg_pa,
  input  logic          bat_we,
  input  logic [IW-1:0] bat_idx,
  input  logic          bat_wvalid,
  input  logic [BW-1:0] bat_wepn,
  input  logic [BW-1:0] bat_wppn,
  input  logic [MW-1:0] bat_wmask,
  output logic [AW-1:0] pa,
  output logic          pa_valid,
  output logic          miss,
  output logic          bat_hit
);

  logic [NENT-1:0] ent_v;
  logic [BW-1:0]   ent_ep [NENT];
  logic [BW-1:0]   ent_pp [NENT];
  logic [MW-1:0]   ent_m  [NENT];

  logic [NENT-1:0] hit;
  logic [BW-1:0]   sub [NENT];
  logic [BW-1:0]   sel_blk;
  logic            any_hit;

  wire [BW-1:0] ea_blk = ea[AW-1:OFFW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < NENT; i++) begin
        ent_ep[i] <= '0;
        ent_pp[i] <= '0;
        ent_m[i]  <= '0;
      end
    end else if (bat_we) begin
      ent_v[bat_idx]  <= bat_wvalid;
      ent_ep[bat_idx] <= bat_wepn;
      ent_pp[bat_idx] <= bat_wppn;
      ent_m[bat_idx]  <= bat_wmask;
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    wire [BW-1:0] lm = {{(BW-MW){1'b0}}, ent_m[g]};
    assign hit[g] = ent_v[g] && (((ea_blk ^ ent_ep[g]) & ~lm) == '0);
    assign sub[g] = (ent_pp[g] & ~lm) | (ea_blk & lm);
  end

  always_comb begin
    sel_blk = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (hit[i]) sel_blk = sub[i];
  end

  assign any_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= '0; pa_valid <= 1'b0; miss <= 1'b0; bat_hit <= 1'b0;
    end else if (!xlate_en) begin
      pa <= ea; pa_valid <= 1'b1; miss <= 1'b0; bat_hit <= 1'b0;
    end else if (any_hit) begin
      pa <= {sel_blk, ea[OFFW-1:0]}; pa_valid <= 1'b1; miss <= 1'b0; bat_hit <= 1'b1;
    end else if (pg_valid) begin
      pa <= pg_pa; pa_valid <= 1'b1; miss <= 1'b0; bat_hit <= 1'b0;
    end else begin
      pa <= '0; pa_valid <= 1'b0; miss <= 1'b1; bat_hit <= 1'b0;
    end
  end

  p_real_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |=> (pa == $past(ea)) && pa_valid && !bat_hit && !miss);

  p_offset_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && any_hit) |=> pa[OFFW-1:0] == $past(ea[OFFW-1:0]));

  p_hit_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && any_hit && pg_valid) |=> bat_hit && pa_valid);

  p_miss_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && !any_hit && !pg_valid) |=> miss && !pa_valid);

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss, pa_valid}) && !(miss && bat_hit));

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && hit[0]) |=> pa[AW-1:OFFW] == $past(sub[0]));

  p_mask_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bat_we |-> ((bat_wmask + 1'b1) & bat_wmask) == '0);

endmodule

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] ea = 0, pg_pa = 0;
  logic        xlate_en = 0, pg_valid = 0;
  logic        bat_we = 0, bat_wvalid = 0;
  logic [1:0]  bat_idx = 0;
  logic [14:0] bat_wepn = 0, bat_wppn = 0;
  logic [10:0] bat_wmask = 0;
  logic [31:0] pa;
  logic        pa_valid, miss, bat_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  bat_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .ea(ea), .xlate_en(xlate_en),
    .pg_valid(pg_valid), .pg_pa(pg_pa), .bat_we(bat_we), .bat_idx(bat_idx),
    .bat_wvalid(bat_wvalid), .bat_wepn(bat_wepn), .bat_wppn(bat_wppn),
    .bat_wmask(bat_wmask), .pa(pa), .pa_valid(pa_valid), .miss(miss),
    .bat_hit(bat_hit)
  );

  typedef struct {
    logic [31:0] pa;
    logic        v, m, h;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;

  logic        mv [4];
  logic [14:0] mep [4], mpp [4];
  logic [10:0] mmk [4];

  task automatic chk(bit ok, string req, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic exp_t model(logic [31:0] a, logic en, logic pv, logic [31:0] pp, string req);
    exp_t e;
    logic [14:0] m;
    e.req = req;
    if (!en) begin
      e.pa = a; e.v = 1; e.m = 0; e.h = 0; return e;
    end
    for (int i = 0; i < 4; i++) begin
      m = {4'b0, mmk[i]};
      if (mv[i] && ((a[31:17] & ~m) == (mep[i] & ~m))) begin
        e.pa = {(mpp[i] & ~m) | (a[31:17] & m), a[16:0]};
        e.v = 1; e.m = 0; e.h = 1; return e;
      end
    end
    if (pv) begin
      e.pa = pp; e.v = 1; e.m = 0; e.h = 0;
    end else begin
      e.pa = 0; e.v = 0; e.m = 1; e.h = 0;
    end
    return e;
  endfunction

  task automatic step(logic [31:0] a, logic en, logic pv, logic [31:0] pp, string req,
                      logic we = 0, logic [1:0] idx = 0, logic wv = 0,
                      logic [14:0] wep = 0, logic [14:0] wpp = 0, logic [10:0] wm = 0);
    @(negedge clk);
    ea = a; xlate_en = en; pg_valid = pv; pg_pa = pp;
    bat_we = we; bat_idx = idx; bat_wvalid = wv; bat_wepn = wep; bat_wppn = wpp; bat_wmask = wm;
    exp_q.push_back(model(a, en, pv, pp, req));
    if (we) begin
      mv[idx] = wv; mep[idx] = wep; mpp[idx] = wpp; mmk[idx] = wm;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(pa == e.pa && pa_valid == e.v && miss == e.m && bat_hit == e.h, e.req,
          $sformatf("got pa=%h v=%b m=%b h=%b exp pa=%h v=%b m=%b h=%b",
                    pa, pa_valid, miss, bat_hit, e.pa, e.v, e.m, e.h));
    end
  end

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mep[i] = 0; mpp[i] = 0; mmk[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: outputs idle after reset
    chk(pa == 0 && !pa_valid && !miss && !bat_hit, "R1",
        $sformatf("got pa=%h v=%b m=%b h=%b exp all 0", pa, pa_valid, miss, bat_hit));
    // R1/R7: no valid entry after reset, page absent
    step(32'h0002_1234, 1, 0, 32'h0, "R1 R7 miss after reset");
    // R2: real mode
    step(32'hDEAD_BEEF, 0, 1, 32'h1111_2222, "R2 real mode");
    // R9: write entry0 and lookup the same cycle -> old contents (page result)
    step(32'h0002_1234, 1, 1, 32'h5555_0000, "R9 same-cycle write sees old",
         1, 2'd0, 1, 15'h0001, 15'h7F00, 11'h000);
    // R3 R4 R5: hit overrides page
    step(32'h0002_1234, 1, 1, 32'h5555_0000, "R5 hit overrides page");
    step(32'h0003_FFFF, 1, 0, 32'h0, "R4 offset kept");
    // R6: neighbouring block index misses, page used
    step(32'h0000_1234, 1, 1, 32'hABCD_0123, "R6 page fallback");
    // 256MB entry1
    step(32'h0, 1, 0, 32'h0, "R7 miss", 1, 2'd1, 1, 15'h0800, 15'h2800, 11'h7FF);
    step(32'h1ABC_DEF0, 1, 0, 32'h0, "R4 256MB substitute");
    // R3: top nibble always compared
    step(32'h2ABC_DEF0, 1, 0, 32'h0, "R3 top bits compared R7");
    // R8: overlapping entries
    step(32'h0, 0, 0, 32'h0, "R2", 1, 2'd2, 1, 15'h0000, 15'h4000, 11'h001);
    step(32'h0, 0, 0, 32'h0, "R2", 1, 2'd3, 1, 15'h0800, 15'h6000, 11'h3FF);
    step(32'h0002_0040, 1, 0, 32'h0, "R8 entry0 over entry2");
    step(32'h0000_0040, 1, 0, 32'h0, "R3 entry2 masked bit");
    step(32'h1000_0008, 1, 1, 32'h7777_7777, "R8 entry1 over entry3");
    step(32'h0002_0040, 0, 0, 32'h0, "R2 real mode ignores entries");
    // R9: invalidate entry0
    step(32'h0, 0, 0, 32'h0, "R9", 1, 2'd0, 0, 15'h0001, 15'h7F00, 11'h000);
    step(32'h0002_0040, 1, 0, 32'h0, "R9 invalidated entry falls to entry2");
    // mixed patterns
    r = 32'h1357_9BDF;
    for (int k = 0; k < 48; k++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      step({r[31:29] == 3'd0 ? 4'h0 : (r[28] ? 4'h1 : r[31:28]), r[27:0]},
           (k % 5) != 0, r[3], ~r, "R3 R4 R6 R7 mixed");
    end
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule